// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block is the register front end for a group of three timer channels. It occupies a 4 KB address window and sits on a simple single-cycle bus: a byte address, write data, a write strobe, a read strobe and registered read data. Registers of one kind for the three channels sit in three consecutive words. The decoder takes the word index, divides it by three to find the register kind, and uses the remainder to pick the channel.

For each channel the block holds the configuration: clock control, counter control, interval, three match values, interrupt enable and event control. It drives this configuration out to separate counting blocks. It also reads back each channel's live count and event value, which those blocks supply. Status events from a channel are collected in a sticky interrupt status register. Reading that register returns its bits and clears it. Each channel has its own interrupt line.

A counter control write with the reset bit set zeroes the channel's count. The block does this by sending a one-cycle pulse to the counting block. The reset bit itself is never stored.

Top module: `tri_timer_regs`

## Requirements
- R1: The channel is the byte address word index (addr[11:2]) mod 3, and the register kind is that word index divided by 3. The kinds, in word-index order, are: clock control, counter control, count value, interval, match 1, match 2, match 3, interrupt status, interrupt enable, event control, event value. So the first word of each kind is at byte offset 0x00, 0x0C, 0x18, 0x24, 0x30, 0x3C, 0x48, 0x54, 0x60, 0x6C and 0x78 respectively.
- R2: A write stores only the masked bits: 6 bits (bits 5:0) for clock control, counter control and interrupt enable; 16 bits for interval and the match registers; 3 bits for event control. A later read returns the stored value zero-extended to 32 bits.
- R3: A counter control write whose data bit 4 is 1 makes cnt_zero_o of that channel high for exactly the one cycle after the write. Bit 4 always reads back, and is driven out, as 0.
- R4: A read of the count value returns that channel's cnt_value_i, and a read of the event value returns that channel's evt_value_i, both zero-extended. A write to either of these registers changes no configuration output and no stored register.
- R5: A status_set_i bit that is 1 in a cycle sets the matching interrupt status bit, and the bit stays set until it is read. A status read returns the bits held before the read and clears them at the same clock edge. A set that arrives in the cycle of the read is kept.
- R6: A write to interrupt status has no effect on the status bits.
- R7: irq_o of a channel is high exactly when some interrupt status bit of that channel and the same bit of its interrupt enable are both 1.
- R8: A read of any byte offset above 0x80 in the window returns 0. A write there changes nothing.
- R9: A write to one match register leaves the other two match registers of that channel, and those of every other channel, unchanged.
- R10: bus_rdata carries the data for a read in the cycle after the read strobe, and is 0 in a cycle that follows no read.
- R11: After a synchronous reset, counter control is 0x21 in every channel. Every other stored register, bus_rdata, cnt_zero_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| cnt_value_i | input | 3x16 | Live count from each channel |
| evt_value_i | input | 3x16 | Event value from each channel |
| status_set_i | input | 3x6 | Status event pulses from each channel |
| clk_cfg_o | output | 3x6 | Clock control per channel |
| ctl_cfg_o | output | 3x6 | Counter control per channel (bit 4 always 0) |
| interval_o | output | 3x16 | Interval per channel |
| match_o | output | 3x3x16 | Three match values per channel |
| evt_cfg_o | output | 3x3 | Event control per channel |
| cnt_zero_o | output | 3 | One-cycle count-zero pulse per channel |
| irq_o | output | 3 | Interrupt line per channel |

## Verification
The assertions take the bus address to be word-aligned. They assume the channel blocks raise a status event only for a reason the checker can see at the ports. For example, the clear-after-read property assumes no set for that channel in the cycle of the read.

The stimulus uses only aligned addresses. It holds status_set_i at zero except in the cycles where a status event is under test. It holds the count and event inputs steady while their words are read, so the expected read data is simply the value being driven.

// File: rtl/tri_timer_regs_pkg.sv
package tri_timer_regs_pkg;
    localparam int NCH      = 3;
    localparam int CH_W     = $clog2(NCH);
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int NARROW_W = 6;
    localparam int HALF_W   = 16;
    localparam int EVC_W    = 3;
    localparam int NMATCH   = 3;
    localparam int NKIND    = 11;
    localparam int ZERO_BIT = 4;
    localparam logic [NARROW_W-1:0] CTL_RST_VAL = 6'h21;

    typedef enum logic [3:0] {
        K_CLK, K_CTL, K_CNT, K_INTV, K_M1, K_M2, K_M3,
        K_STAT, K_IEN, K_EVC, K_EVV, K_NONE
    } kind_e;

    typedef struct packed {
        logic [NARROW_W-1:0]           clk;
        logic [NARROW_W-1:0]           ctl;
        logic [HALF_W-1:0]             intv;
        logic [NMATCH-1:0][HALF_W-1:0] match;
        logic [NARROW_W-1:0]           ien;
        logic [EVC_W-1:0]              evc;
    } chan_cfg_t;

    typedef struct packed {
        kind_e           kind;
        logic [CH_W-1:0] ch;
    } dec_t;

    function automatic dec_t decode(logic [ADDR_W-1:0] addr);
        dec_t d;
        int   w;
        w = int'(addr[ADDR_W-1:2]);
        if (w < NCH * NKIND) begin
            d.kind = kind_e'(4'(w / NCH));
            d.ch   = CH_W'(w % NCH);
        end else begin
            d.kind = K_NONE;
            d.ch   = '0;
        end
        return d;
    endfunction
endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
    import tri_timer_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    always_comb dec_o = decode(addr_i);
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tri_timer_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic                rd_i,
    input  kind_e               kind_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NARROW_W-1:0] set_i,
    output chan_cfg_t           cfg_o,
    output logic [NARROW_W-1:0] status_o,
    output logic                irq_o,
    output logic                zero_o
);
    localparam logic [NARROW_W-1:0] KEEP_CTL = ~(NARROW_W'(1) << ZERO_BIT);

    chan_cfg_t           cfg_q;
    logic [NARROW_W-1:0] stat_q;
    logic                zero_q;
    logic                rd_clr;

    assign rd_clr = rd_i && (kind_i == K_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            cfg_q.ctl <= CTL_RST_VAL;
            stat_q    <= '0;
            zero_q    <= 1'b0;
        end else begin
            zero_q <= 1'b0;
            stat_q <= (stat_q & ~{NARROW_W{rd_clr}}) | set_i;
            if (wr_i) begin
                case (kind_i)
                    K_CLK:  cfg_q.clk      <= wdata_i[NARROW_W-1:0];
                    K_CTL: begin
                        cfg_q.ctl <= wdata_i[NARROW_W-1:0] & KEEP_CTL;
                        zero_q    <= wdata_i[ZERO_BIT];
                    end
                    K_INTV: cfg_q.intv     <= wdata_i[HALF_W-1:0];
                    K_M1:   cfg_q.match[0] <= wdata_i[HALF_W-1:0];
                    K_M2:   cfg_q.match[1] <= wdata_i[HALF_W-1:0];
                    K_M3:   cfg_q.match[2] <= wdata_i[HALF_W-1:0];
                    K_IEN:  cfg_q.ien      <= wdata_i[NARROW_W-1:0];
                    K_EVC:  cfg_q.evc      <= wdata_i[EVC_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign cfg_o    = cfg_q;
    assign status_o = stat_q;
    assign zero_o   = zero_q;
    assign irq_o    = |(stat_q & cfg_q.ien);
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tri_timer_regs_pkg::*;
(
    input  dec_t                          dec_i,
    input  chan_cfg_t                     cfg_i    [NCH],
    input  logic [NCH-1:0][NARROW_W-1:0]  status_i,
    input  logic [NCH-1:0][HALF_W-1:0]    cnt_i,
    input  logic [NCH-1:0][HALF_W-1:0]    evv_i,
    output logic [DATA_W-1:0]             data_o
);
    int        idx;
    chan_cfg_t c;

    always_comb begin
        idx    = (int'(dec_i.ch) < NCH) ? int'(dec_i.ch) : 0;
        c      = cfg_i[idx];
        data_o = '0;
        case (dec_i.kind)
            K_CLK:  data_o = DATA_W'(c.clk);
            K_CTL:  data_o = DATA_W'(c.ctl);
            K_CNT:  data_o = DATA_W'(cnt_i[idx]);
            K_INTV: data_o = DATA_W'(c.intv);
            K_M1:   data_o = DATA_W'(c.match[0]);
            K_M2:   data_o = DATA_W'(c.match[1]);
            K_M3:   data_o = DATA_W'(c.match[2]);
            K_STAT: data_o = DATA_W'(status_i[idx]);
            K_IEN:  data_o = DATA_W'(c.ien);
            K_EVC:  data_o = DATA_W'(c.evc);
            K_EVV:  data_o = DATA_W'(evv_i[idx]);
            default: data_o = '0;
        endcase
    end
endmodule

// File: rtl/tri_timer_regs.sv
module tri_timer_regs
    import tri_timer_regs_pkg::*;
(
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic [ADDR_W-1:0]                          bus_addr,
    input  logic [DATA_W-1:0]                          bus_wdata,
    input  logic                                       bus_we,
    input  logic                                       bus_re,
    output logic [DATA_W-1:0]                          bus_rdata,
    input  logic [NCH-1:0][HALF_W-1:0]                 cnt_value_i,
    input  logic [NCH-1:0][HALF_W-1:0]                 evt_value_i,
    input  logic [NCH-1:0][NARROW_W-1:0]               status_set_i,
    output logic [NCH-1:0][NARROW_W-1:0]               clk_cfg_o,
    output logic [NCH-1:0][NARROW_W-1:0]               ctl_cfg_o,
    output logic [NCH-1:0][HALF_W-1:0]                 interval_o,
    output logic [NCH-1:0][NMATCH-1:0][HALF_W-1:0]     match_o,
    output logic [NCH-1:0][EVC_W-1:0]                  evt_cfg_o,
    output logic [NCH-1:0]                             cnt_zero_o,
    output logic [NCH-1:0]                             irq_o
);
    dec_t                          dec;
    chan_cfg_t                     cfg    [NCH];
    logic [NCH-1:0][NARROW_W-1:0]  status;
    logic [DATA_W-1:0]             mux_data;
    logic [DATA_W-1:0]             rdata_q;

    tmr_addr_decode u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit;
        assign hit = (dec.kind != K_NONE) && (int'(dec.ch) == c);

        tmr_chan_regs u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_i     (bus_we && hit),
            .rd_i     (bus_re && hit),
            .kind_i   (dec.kind),
            .wdata_i  (bus_wdata),
            .set_i    (status_set_i[c]),
            .cfg_o    (cfg[c]),
            .status_o (status[c]),
            .irq_o    (irq_o[c]),
            .zero_o   (cnt_zero_o[c])
        );

        assign clk_cfg_o[c]  = cfg[c].clk;
        assign ctl_cfg_o[c]  = cfg[c].ctl;
        assign interval_o[c] = cfg[c].intv;
        assign match_o[c]    = cfg[c].match;
        assign evt_cfg_o[c]  = cfg[c].evc;
    end

    tmr_read_mux u_rmux (
        .dec_i    (dec),
        .cfg_i    (cfg),
        .status_i (status),
        .cnt_i    (cnt_value_i),
        .evv_i    (evt_value_i),
        .data_o   (mux_data)
    );

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= bus_re ? mux_data : '0;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/tri_timer_regs_chk.sv
module tri_timer_regs_chk
    import tri_timer_regs_pkg::*;
(
    input logic                                   clk,
    input logic                                   rst,
    input logic [ADDR_W-1:0]                      bus_addr,
    input logic [DATA_W-1:0]                      bus_wdata,
    input logic                                   bus_we,
    input logic                                   bus_re,
    input logic [DATA_W-1:0]                      bus_rdata,
    input logic [NCH-1:0][NARROW_W-1:0]           status_set_i,
    input logic [NCH-1:0][NARROW_W-1:0]           clk_cfg_o,
    input logic [NCH-1:0][NARROW_W-1:0]           ctl_cfg_o,
    input logic [NCH-1:0][HALF_W-1:0]             interval_o,
    input logic [NCH-1:0][NMATCH-1:0][HALF_W-1:0] match_o,
    input logic [NCH-1:0][EVC_W-1:0]              evt_cfg_o,
    input logic [NCH-1:0]                         cnt_zero_o,
    input logic [NCH-1:0]                         irq_o
);
    logic [NCH*(2*NARROW_W+HALF_W*(1+NMATCH)+EVC_W)-1:0] cfg_all;
    assign cfg_all = {clk_cfg_o, ctl_cfg_o, interval_o, match_o, evt_cfg_o};

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctl_cfg_o[0] == CTL_RST_VAL) && (irq_o == '0) && (bus_rdata == '0));

    // R3
    zero_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 12'h00C && bus_wdata[ZERO_BIT]) |=> cnt_zero_o[0]);

    // R3
    zero_bit_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 12'h010) |=> !ctl_cfg_o[1][ZERO_BIT]);

    // R4
    count_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == 12'h018 || bus_addr == 12'h01C || bus_addr == 12'h020))
        |=> $stable(cfg_all));

    // R8
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr > 12'h080) |=> $stable(cfg_all));

    // R8
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr > 12'h080) |=> (bus_rdata == '0));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (bus_rdata == '0));

    // R5
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == 12'h054 && status_set_i[0] == '0) |=> !irq_o[0]);

    // R9
    match_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 12'h030) |=> ($stable(match_o[0][1]) && $stable(match_o[0][2])));
endmodule

bind tri_timer_regs tri_timer_regs_chk u_chk (.*);

// File: tb/tri_timer_regs_test.sv
module tri_timer_regs_test;
    import tri_timer_regs_pkg::*;

    logic                                   clk = 1'b0;
    logic                                   rst = 1'b1;
    logic [ADDR_W-1:0]                      bus_addr = '0;
    logic [DATA_W-1:0]                      bus_wdata = '0;
    logic                                   bus_we = 1'b0;
    logic                                   bus_re = 1'b0;
    logic [DATA_W-1:0]                      bus_rdata;
    logic [NCH-1:0][HALF_W-1:0]             cnt_value_i;
    logic [NCH-1:0][HALF_W-1:0]             evt_value_i;
    logic [NCH-1:0][NARROW_W-1:0]           status_set_i = '0;
    logic [NCH-1:0][NARROW_W-1:0]           clk_cfg_o;
    logic [NCH-1:0][NARROW_W-1:0]           ctl_cfg_o;
    logic [NCH-1:0][HALF_W-1:0]             interval_o;
    logic [NCH-1:0][NMATCH-1:0][HALF_W-1:0] match_o;
    logic [NCH-1:0][EVC_W-1:0]              evt_cfg_o;
    logic [NCH-1:0]                         cnt_zero_o;
    logic [NCH-1:0]                         irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DATA_W-1:0] model [NCH*NKIND];

    always #5 clk = ~clk;

    tri_timer_regs uut (.*);

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(int a, logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(int a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [DATA_W-1:0] kind_mask(int k);
        case (k)
            0, 8:          return 32'h3F;
            1:             return 32'h2F;
            3, 4, 5, 6:    return 32'hFFFF;
            9:             return 32'h7;
            default:       return 32'h0;
        endcase
    endfunction

    function automatic bit kind_stored(int k);
        return kind_mask(k) != 0;
    endfunction

    function automatic logic [DATA_W-1:0] pattern(int w, int salt);
        return 32'hC3A5_5A3C ^ (DATA_W'(w + salt) * 32'h9E37_79B9);
    endfunction

    task automatic verify_model(string req);
        logic [DATA_W-1:0] rd;
        for (int w = 0; w < NCH * NKIND; w++) begin
            do_read(w * 4, rd);
            case (w / NCH)
                2:  check({req, " count read"}, rd, DATA_W'(cnt_value_i[w % NCH]));
                7:  check({req, " status read"}, rd, 32'h0);
                10: check({req, " event read"}, rd, DATA_W'(evt_value_i[w % NCH]));
                default: check(req, rd, model[w]);
            endcase
        end
    endtask

    initial begin
        logic [DATA_W-1:0] rd;
        logic [NCH*(2*NARROW_W+HALF_W*(1+NMATCH)+EVC_W)-1:0] snap;

        cnt_value_i = {16'h3333, 16'h2222, 16'h1111};
        evt_value_i = {16'hC00C, 16'hB00B, 16'hA00A};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        for (int c = 0; c < NCH; c++) begin
            check("R11 ctl reset", DATA_W'(ctl_cfg_o[c]), 32'h21);
            check("R11 clk reset", DATA_W'(clk_cfg_o[c]), 32'h0);
            check("R11 match reset", DATA_W'(match_o[c][0]), 32'h0);
        end
        check("R11 irq reset", DATA_W'(irq_o), 32'h0);
        check("R11 rdata reset", bus_rdata, 32'h0);
        check("R11 zero reset", DATA_W'(cnt_zero_o), 32'h0);

        for (int w = 0; w < NCH * NKIND; w++)
            model[w] = (w / NCH == 1) ? 32'h21 : 32'h0;

        // R1 R2 sweep: write every word in the window range, read everything back
        for (int w = 0; w < NCH * NKIND; w++) begin
            do_write(w * 4, pattern(w, 0));
            if (kind_stored(w / NCH)) model[w] = pattern(w, 0) & kind_mask(w / NCH);
        end
        verify_model("R1 R2 R4 R6 readback");

        // R10 idle cycle after a read gives zero data
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'h0);

        // R4 count and event values follow the inputs
        cnt_value_i = {16'hFFFF, 16'h0001, 16'h8000};
        evt_value_i = {16'h0000, 16'h7FFF, 16'h5A5A};
        for (int c = 0; c < NCH; c++) begin
            do_read(12'h018 + c * 4, rd);
            check("R4 count", rd, DATA_W'(cnt_value_i[c]));
            do_read(12'h078 + c * 4, rd);
            check("R4 event", rd, DATA_W'(evt_value_i[c]));
        end
        snap = {clk_cfg_o, ctl_cfg_o, interval_o, match_o, evt_cfg_o};
        do_write(12'h01C, 32'hFFFF_FFFF);
        do_write(12'h07C, 32'hFFFF_FFFF);
        check("R4 write ignored", 32'(snap != {clk_cfg_o, ctl_cfg_o, interval_o, match_o, evt_cfg_o}), 32'h0);

        // R8 out of range writes and reads
        for (int w = NCH * NKIND; w < 1024; w++) begin
            do_write(w * 4, pattern(w, 7));
            do_read(w * 4, rd);
            check("R8 oob read", rd, 32'h0);
        end
        verify_model("R8 oob write no effect");

        // R9 match independence, channel 1
        do_write(12'h034, 32'h0000_1234);
        model[13] = 32'h1234;
        do_read(12'h040, rd);
        check("R9 match2 unchanged", rd, model[16]);
        do_read(12'h04C, rd);
        check("R9 match3 unchanged", rd, model[19]);
        do_read(12'h038, rd);
        check("R9 other channel match1 unchanged", rd, model[14]);
        do_read(12'h034, rd);
        check("R9 match1 written", rd, 32'h1234);

        // R3 counter control zero pulse on channel 1
        do_write(12'h010, 32'h0000_003F);
        check("R3 zero pulse", DATA_W'(cnt_zero_o), 32'h2);
        check("R3 bit4 dropped", DATA_W'(ctl_cfg_o[1]), 32'h2F);
        @(negedge clk);
        check("R3 pulse one cycle", DATA_W'(cnt_zero_o), 32'h0);
        do_write(12'h014, 32'h0000_000F);
        check("R3 no pulse bit4 clear", DATA_W'(cnt_zero_o), 32'h0);

        // R7 R5 status and interrupt on channel 2
        do_write(12'h068, 32'h3F);
        do_write(12'h060, 32'h01);
        do_write(12'h064, 32'h00);
        @(negedge clk);
        status_set_i[2] = 6'b000101;
        @(negedge clk);
        status_set_i[2] = '0;
        check("R7 irq channel 2", DATA_W'(irq_o), 32'h4);
        @(negedge clk);
        check("R5 sticky", DATA_W'(irq_o), 32'h4);
        do_read(12'h05C, rd);
        check("R5 status read", rd, 32'h05);
        check("R5 cleared irq", DATA_W'(irq_o), 32'h0);
        do_read(12'h05C, rd);
        check("R5 status empty", rd, 32'h0);

        // R5 R7 collision on channel 0 with partial enable
        @(negedge clk);
        status_set_i[0] = 6'b000001;
        @(negedge clk);
        status_set_i[0] = 6'b000010;
        bus_addr = 12'h054; bus_re = 1'b1;
        @(negedge clk);
        status_set_i[0] = '0; bus_re = 1'b0;
        check("R5 collision read", bus_rdata, 32'h01);
        check("R7 masked bit no irq", DATA_W'(irq_o[0]), 32'h0);
        do_read(12'h054, rd);
        check("R5 set kept", rd, 32'h02);

        // R6 status write ignored, channel 1 (enable 0 so irq stays low)
        @(negedge clk);
        status_set_i[1] = 6'b001000;
        @(negedge clk);
        status_set_i[1] = '0;
        do_write(12'h058, 32'h0);
        do_write(12'h058, 32'h3F);
        check("R7 enable zero no irq", DATA_W'(irq_o[1]), 32'h0);
        do_read(12'h058, rd);
        check("R6 status write ignored", rd, 32'h08);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule